// File: doc/BRIEF.md
# Wrapping burst read controller for a shared address/data flash bus

This block sits on the host side of a flash device whose low address bits and data share one 16-bit bus. It turns a single request from the user side into a complete 8-word burst read on the device pins. It drives chip select, a one-cycle address strobe and read enable. The low 16 address bits go out on the shared bus and the remaining upper bits go out on dedicated lines. It then waits a programmable number of clock edges and collects eight words. The words come back in wrap order inside the aligned 8-word group that holds the requested word.

The device paces the transfer with a ready line. A static mode input selects whether ready arrives in the same cycle as the word it qualifies or one cycle earlier. Each collected word is handed to the user as a one-cycle valid pulse with the data and its position inside the group. The eighth word also raises a done flag, and in that same cycle the device is deselected.

Top module: `mux_burst_rdctl`

## Requirements
- R1: A request seen while idle causes, in the next cycle only, `fl_ce_n`=0, `fl_avd_n`=0, `fl_ad_oe`=1, `fl_ad_out` = `req_addr[15:0]` and `fl_addr_hi` = `req_addr[24:16]`. `fl_avd_n` is low for exactly that one cycle.
- R2: After the address cycle the host stops driving the shared bus (`fl_ad_oe`=0). `fl_oe_n` stays high during the first cycle after the address cycle and goes low on the edge that follows it. `fl_oe_n` is never low while the host drives the bus or while `fl_ce_n` is high.
- R3: Counting the edge that closes the address cycle as edge 0, the first word may be sampled on edge L. L is `cfg_latency` clamped to the range 2..16, so codes 0 and 1 act as 2 and codes above 16 act as 16.
- R4: With `cfg_rdy_early`=0, a word is taken at a sampling edge only if `fl_rdy` is 1 at that edge. A 0 or an undriven `fl_rdy` keeps the position, and the word is taken at a later edge.
- R5: With `cfg_rdy_early`=1, a word is taken at a sampling edge only if `fl_rdy` was 1 at the previous edge.
- R6: The start position is `req_addr[2:0]`. The words come back at positions s, s+1, … modulo 8 within the group. Each taken word gives `rd_valid`=1 for one cycle, in the cycle right after its sampling edge. In that cycle `rd_data` carries the bus value sampled at that edge and `rd_idx` carries the position.
- R7: `rd_done` is 1 together with the eighth `rd_valid` and at no other time. In that same cycle `fl_ce_n` and `fl_oe_n` are both 1.
- R8: A request made while a burst is in progress is ignored. No new address strobe appears, the upper address lines do not change, and the word stream is unchanged.
- R9: After reset the outputs are idle: `fl_ce_n`, `fl_avd_n` and `fl_oe_n` are 1, and `fl_ad_oe`, `rd_valid` and `rd_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_latency | input | 5 | Initial latency code, clamped to 2..16 |
| cfg_rdy_early | input | 1 | 1: ready leads its data word by one cycle |
| req | input | 1 | Start a burst (taken only when idle) |
| req_addr | input | 25 | Word address of the first word |
| rd_valid | output | 1 | One returned word is present |
| rd_data | output | 16 | Returned word |
| rd_idx | output | 3 | Position of the word inside its 8-word group |
| rd_done | output | 1 | Marks the eighth word of the burst |
| fl_ce_n | output | 1 | Device chip select, active low |
| fl_avd_n | output | 1 | Address strobe, active low |
| fl_oe_n | output | 1 | Device read enable, active low |
| fl_addr_hi | output | 9 | Upper address lines |
| fl_ad_out | output | 16 | Value the host drives onto the shared bus |
| fl_ad_oe | output | 1 | Host drives the shared bus when 1 |
| fl_ad_in | input | 16 | Value read from the shared bus |
| fl_rdy | input | 1 | Device ready |

## Verification
The address cycle is due one cycle after the accepting edge. The bus release comes one edge after that, and read enable one edge later still. A word's valid pulse is due in the cycle right after its sampling edge, and that edge is at L plus the number of stalled edges after the address cycle closes. The bench holds a cycle-accurate model of the device. This model counts edges from the address strobe, decides at each edge whether a word is taken, and checks every output half a cycle after that edge. So each result is compared in the exact cycle it is due, never within a window.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_DATA
  } mbr_state_e;

  // Effective latency: configuration code forced into [lo, hi].
  function automatic int unsigned clamp_latency(input int unsigned code,
                                                input int unsigned lo,
                                                input int unsigned hi);
    if (code < lo) return lo;
    if (code > hi) return hi;
    return code;
  endfunction

  // Next position inside a power-of-two wrap group.
  function automatic int unsigned wrap_step(input int unsigned pos,
                                            input int unsigned group);
    return (pos + 1) % group;
  endfunction

endpackage

// File: rtl/mbr_lat_timer.sv
module mbr_lat_timer #(
  parameter int LAT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [LAT_W-1:0] lat,
  output logic             hit
);
  logic [LAT_W-1:0] edge_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     edge_cnt <= '0;
    else if (start) edge_cnt <= LAT_W'(1);
    else if (run)   edge_cnt <= edge_cnt + LAT_W'(1);
  end

  // The edge numbered lat-1 is the last waiting edge.
  assign hit = run && (edge_cnt == lat - LAT_W'(1));
endmodule

// File: rtl/mbr_wrap_seq.sv
module mbr_wrap_seq
  import mbr_pkg::*;
#(
  parameter int BURST_LEN = 8,
  localparam int IDX_W = $clog2(BURST_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] start_idx,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  logic [IDX_W-1:0] taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      taken <= '0;
    end else if (load) begin
      idx   <= start_idx;
      taken <= '0;
    end else if (step) begin
      idx   <= IDX_W'(wrap_step(32'(idx), BURST_LEN));
      taken <= taken + IDX_W'(1);
    end
  end

  assign last = (taken == IDX_W'(BURST_LEN - 1));
endmodule

// File: rtl/mbr_rdy_qual.sv
module mbr_rdy_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_in,
  input  logic early,
  output logic take_ok
);
  logic rdy_now;
  logic rdy_prev;

  // Only a driven 1 counts; an undriven line never compares equal.
  assign rdy_now = (rdy_in == 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_prev <= 1'b0;
    else        rdy_prev <= rdy_now;
  end

  assign take_ok = early ? rdy_prev : rdy_now;
endmodule

// File: rtl/mux_burst_rdctl.sv
module mux_burst_rdctl
  import mbr_pkg::*;
#(
  parameter int ADDR_W    = 25,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 8,
  parameter int LAT_W     = 5,
  parameter int LAT_MIN   = 2,
  parameter int LAT_MAX   = 16,
  localparam int HI_W  = ADDR_W - DATA_W,
  localparam int IDX_W = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAT_W-1:0]  cfg_latency,
  input  logic              cfg_rdy_early,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              rd_done,
  output logic              fl_ce_n,
  output logic              fl_avd_n,
  output logic              fl_oe_n,
  output logic [HI_W-1:0]   fl_addr_hi,
  output logic [DATA_W-1:0] fl_ad_out,
  output logic              fl_ad_oe,
  input  logic [DATA_W-1:0] fl_ad_in,
  input  logic              fl_rdy
);
  mbr_state_e       st;
  logic [LAT_W-1:0] lat_q;
  logic             early_q;

  // Named internal events.
  logic             req_accept;
  logic             addr_phase_end;
  logic             lat_hit;
  logic             take_ok;
  logic             word_take;
  logic             burst_last;
  logic [IDX_W-1:0] cur_idx;

  assign req_accept     = (st == ST_IDLE) && req;
  assign addr_phase_end = (st == ST_ADDR);
  assign word_take      = (st == ST_DATA) && take_ok;

  mbr_lat_timer #(.LAT_W(LAT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (addr_phase_end),
    .run   (st == ST_WAIT),
    .lat   (lat_q),
    .hit   (lat_hit)
  );

  mbr_wrap_seq #(.BURST_LEN(BURST_LEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (req_accept),
    .start_idx (req_addr[IDX_W-1:0]),
    .step      (word_take),
    .idx       (cur_idx),
    .last      (burst_last)
  );

  mbr_rdy_qual u_rdy (
    .clk     (clk),
    .rst_n   (rst_n),
    .rdy_in  (fl_rdy),
    .early   (early_q),
    .take_ok (take_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      lat_q      <= LAT_W'(LAT_MIN);
      early_q    <= 1'b0;
      fl_ce_n    <= 1'b1;
      fl_avd_n   <= 1'b1;
      fl_oe_n    <= 1'b1;
      fl_ad_oe   <= 1'b0;
      fl_ad_out  <= '0;
      fl_addr_hi <= '0;
      rd_valid   <= 1'b0;
      rd_done    <= 1'b0;
      rd_data    <= '0;
      rd_idx     <= '0;
    end else begin
      rd_valid <= 1'b0;
      rd_done  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req) begin
            st         <= ST_ADDR;
            lat_q      <= LAT_W'(clamp_latency(32'(cfg_latency), LAT_MIN, LAT_MAX));
            early_q    <= cfg_rdy_early;
            fl_ce_n    <= 1'b0;
            fl_avd_n   <= 1'b0;
            fl_ad_oe   <= 1'b1;
            fl_ad_out  <= req_addr[DATA_W-1:0];
            fl_addr_hi <= req_addr[ADDR_W-1:DATA_W];
          end
        end
        ST_ADDR: begin
          st       <= ST_WAIT;
          fl_avd_n <= 1'b1;
          fl_ad_oe <= 1'b0;
        end
        ST_WAIT: begin
          fl_oe_n <= 1'b0;
          if (lat_hit) st <= ST_DATA;
        end
        ST_DATA: begin
          if (word_take) begin
            rd_valid <= 1'b1;
            rd_data  <= fl_ad_in;
            rd_idx   <= cur_idx;
            if (burst_last) begin
              rd_done <= 1'b1;
              fl_ce_n <= 1'b1;
              fl_oe_n <= 1'b1;
              st      <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbr_checker.sv
module mbr_checker #(
  parameter int BURST_LEN = 8,
  parameter int IDX_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_accept,
  input logic             fl_ce_n,
  input logic             fl_avd_n,
  input logic             fl_oe_n,
  input logic             fl_ad_oe,
  input logic             rd_valid,
  input logic             rd_done,
  input logic [IDX_W-1:0] rd_idx
);
  logic [IDX_W-1:0] prev_idx;
  logic             mid_burst;
  logic [IDX_W:0]   words_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_idx   <= '0;
      mid_burst  <= 1'b0;
      words_seen <= '0;
    end else if (rd_valid) begin
      prev_idx   <= rd_idx;
      mid_burst  <= !rd_done;
      words_seen <= rd_done ? '0 : words_seen + 1'b1;
    end
  end

  assert_strobe_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> !fl_avd_n && !fl_ce_n && fl_ad_oe);

  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_avd_n |=> fl_avd_n);

  assert_no_contention_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_ad_oe |-> fl_oe_n);

  assert_oe_needs_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_ce_n |-> fl_oe_n);

  assert_oe_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_oe_n) |-> $past(fl_avd_n) && !fl_ce_n);

  assert_wrap_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && mid_burst |-> rd_idx == IDX_W'(prev_idx + 1'b1));

  assert_done_with_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> rd_valid && (words_seen == (IDX_W+1)'(BURST_LEN - 1)));

  assert_done_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> fl_ce_n && fl_oe_n);
endmodule

bind mux_burst_rdctl mbr_checker #(.BURST_LEN(BURST_LEN), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_accept (req_accept),
  .fl_ce_n    (fl_ce_n),
  .fl_avd_n   (fl_avd_n),
  .fl_oe_n    (fl_oe_n),
  .fl_ad_oe   (fl_ad_oe),
  .rd_valid   (rd_valid),
  .rd_done    (rd_done),
  .rd_idx     (rd_idx)
);

// File: tb/mux_burst_rdctl_bench.sv
`timescale 1ns/1ps
module mux_burst_rdctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_latency = '0;
  logic        cfg_rdy_early = 1'b0;
  logic        req = 1'b0;
  logic [24:0] req_addr = '0;
  logic        rd_valid, rd_done;
  logic [15:0] rd_data;
  logic [2:0]  rd_idx;
  logic        fl_ce_n, fl_avd_n, fl_oe_n, fl_ad_oe;
  logic [8:0]  fl_addr_hi;
  logic [15:0] fl_ad_out;
  logic [15:0] fl_ad_in;
  logic        fl_rdy;

  always #2.5 clk = ~clk;

  mux_burst_rdctl u_mux_burst_rdctl (
    .clk(clk), .rst_n(rst_n), .cfg_latency(cfg_latency), .cfg_rdy_early(cfg_rdy_early),
    .req(req), .req_addr(req_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_idx(rd_idx), .rd_done(rd_done), .fl_ce_n(fl_ce_n), .fl_avd_n(fl_avd_n),
    .fl_oe_n(fl_oe_n), .fl_addr_hi(fl_addr_hi), .fl_ad_out(fl_ad_out),
    .fl_ad_oe(fl_ad_oe), .fl_ad_in(fl_ad_in), .fl_rdy(fl_rdy)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  bit          m_active = 0;
  int          m_k = 0;
  int          m_p = 0;
  int          m_lat = 2;
  bit          m_early = 0;
  bit          m_stall = 0;
  int          m_seed = 0;
  logic [24:0] m_base = '0;
  bit          acc_last = 0;
  bit          exp_last = 0;
  logic [15:0] exp_d = '0;
  logic [2:0]  exp_i = '0;
  bit          saw_done = 0;

  function automatic int lat_of(input int code);
    if (code < 2) return 2;
    if (code > 16) return 16;
    return code;
  endfunction

  function automatic bit stalled(input int k);
    return m_stall && (((k + m_seed) % 3) == 0);
  endfunction

  function automatic logic [15:0] word_at(input logic [24:0] a);
    logic [31:0] t;
    t = {7'd0, a} * 32'd40503;
    return t[15:0] ^ 16'h3C3C;
  endfunction

  function automatic logic [24:0] addr_of(input int p);
    logic [2:0] pos;
    pos = 3'(int'(m_base[2:0]) + p);
    return {m_base[24:3], pos};
  endfunction

  always @(posedge clk) begin
    acc_last = 0;
    if (!rst_n) m_active = 0;
    else if (!fl_ce_n && !fl_avd_n) begin
      m_active = 1; m_k = 1; m_p = 0;
      m_base = {fl_addr_hi, fl_ad_out};
    end else if (m_active) begin
      if (m_k >= m_lat && !stalled(m_k)) begin
        acc_last = 1;
        exp_d = word_at(addr_of(m_p));
        exp_i = addr_of(m_p)[2:0];
        m_p++;
        exp_last = (m_p == 8);
        if (m_p == 8) m_active = 0;
      end
      m_k++;
    end
  end

  always @(negedge clk) begin
    if (m_active && m_k >= m_lat) fl_ad_in = word_at(addr_of(m_p));
    else fl_ad_in = 'z;
    if (!m_active) fl_rdy = 1'bz;
    else if (m_early) fl_rdy = (m_k + 1 >= m_lat) && !stalled(m_k + 1);
    else fl_rdy = (m_k >= m_lat) && !stalled(m_k);
  end

  function automatic string tlabel();
    if (m_early) return "R5";
    if (m_stall) return "R4";
    return "R3";
  endfunction

  // Output checks half a cycle after every edge of a burst.
  always @(negedge clk) begin
    if (rst_n && acc_last) begin
      check(rd_valid == 1'b1, tlabel(), "word due", rd_valid, 1);
      check(rd_data == exp_d, "R6", "rd_data", rd_data, exp_d);
      check(rd_idx == exp_i, "R6", "rd_idx", rd_idx, exp_i);
      check(rd_done == exp_last, "R7", "rd_done", rd_done, exp_last);
      if (exp_last) begin
        check(fl_ce_n && fl_oe_n, "R7", "release ce/oe", {fl_ce_n, fl_oe_n}, 2'b11);
        saw_done = 1;
      end
    end else if (rst_n && m_active) begin
      check(rd_valid == 1'b0, tlabel(), "no word expected", rd_valid, 0);
      check(rd_done == 1'b0, "R7", "early done", rd_done, 0);
      check(fl_oe_n == (m_k < 2), "R2", "oe timing", fl_oe_n, (m_k < 2));
      check(fl_ad_oe == 1'b0 && fl_avd_n, "R2", "bus released", {fl_ad_oe, fl_avd_n}, 2'b01);
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_burst(input int code, input bit early, input bit stall,
                           input logic [24:0] addr, input bit poke);
    @(negedge clk);
    cfg_latency = 5'(code); cfg_rdy_early = early;
    m_lat = lat_of(code); m_early = early; m_stall = stall; m_seed = int'(addr[4:0]) % 3;
    saw_done = 0;
    req = 1; req_addr = addr;
    @(negedge clk);
    req = 0;
    check(!fl_ce_n && !fl_avd_n && fl_ad_oe, "R1", "address cycle pins",
          {fl_ce_n, fl_avd_n, fl_ad_oe}, 3'b001);
    check(fl_ad_out == addr[15:0], "R1", "low address", fl_ad_out, addr[15:0]);
    check(fl_addr_hi == addr[24:16], "R1", "high address", fl_addr_hi, addr[24:16]);
    if (poke) begin
      repeat (3) @(negedge clk);
      req = 1; req_addr = ~addr;
      @(negedge clk);
      check(fl_avd_n == 1'b1, "R8", "strobe while busy", fl_avd_n, 1);
      check(fl_addr_hi == addr[24:16], "R8", "upper lines while busy", fl_addr_hi, addr[24:16]);
      req = 0;
    end
    for (int i = 0; i < 300 && !saw_done; i++) @(negedge clk);
    check(saw_done, "R7", "burst completed", saw_done, 1);
    @(negedge clk);
  endtask

  int lats[7] = '{0, 2, 3, 7, 13, 16, 31};

  initial begin
    repeat (3) @(negedge clk);
    check(fl_ce_n && fl_avd_n && fl_oe_n, "R9", "reset pins", {fl_ce_n, fl_avd_n, fl_oe_n}, 3'b111);
    check(!fl_ad_oe && !rd_valid && !rd_done, "R9", "reset flags",
          {fl_ad_oe, rd_valid, rd_done}, 0);
    rst_n = 1;
    @(negedge clk);
    check(fl_ce_n && !rd_valid, "R9", "idle after reset", {fl_ce_n, rd_valid}, 2'b10);
    for (int li = 0; li < 7; li++)
      for (int e = 0; e < 2; e++)
        for (int sv = 0; sv < 2; sv++)
          for (int s = 0; s < 8; s++)
            run_burst(lats[li], e[0], sv[0],
                      {9'(li * 37 + e * 5 + sv), 13'(li * 91 + sv * 7 + e * 3), 3'(s)},
                      s == 3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <= 150000 cycles", wd);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule